// File: doc/BRIEF.md
# Dual-Channel Simultaneous-Sampling ADC Frame Reader

This block drives a two-channel serial converter whose two inputs are sampled at the same instant. A single start request, or a free-running rate timer, raises the active-high convert line for one SCK half period. The block then clocks out exactly 34 SCK cycles. It shifts in two 14-bit two's-complement words, channel 0 first, and each word arrives MSB first. The converter's output is high impedance for two slots on each side of each word. The block skips those guard slots.

The converter has a one-sample pipeline. The words read during a frame therefore belong to the convert pulse that came before that frame's own pulse. After a frame ends, the block presents both words as signed values together with a one-cycle valid strobe. The first frame after reset has no earlier conversion behind it, so the block marks its data as stale. A programmable divider sets the SCK half period in system clocks. A programmable period sets the minimum spacing between automatic convert pulses. A new convert pulse never starts inside a running frame.

The control path is one state machine:
- IDLE: waiting for a start.
- CONV: the convert line is high.
- LOW: SCK is low and the data line settles.
- HIGH: SCK is high.
- DONE: the results are published.

The transitions are:
- IDLE→CONV on a request or an automatic tick.
- CONV→LOW after one half period.
- LOW→HIGH after one half period. The data bit is captured on this transition.
- HIGH→LOW after one half period while slots remain.
- HIGH→DONE after the high half of slot 34.
- DONE→IDLE always, after one cycle.

Top module: `dual_adc_reader`

## Requirements
- R1: An accepted start (req_i high, or an automatic tick, while the machine is in IDLE) raises conv_o from the next cycle. conv_o stays high for exactly H = half_div_i+1 clock cycles, and sck_o is low during that time.
- R2: After conv_o falls, sck_o makes exactly 34 low/high periods. Each half period lasts H cycles, and sck_o returns low at the end of the frame.
- R3: ch0_o is built from sdo_i sampled at the end of the low half of slots 3 to 16. ch1_o is built the same way from slots 19 to 32. Slots are counted from 1 after conv_o falls, and the first bit sampled in each window is the MSB. The values on sdo_i in slots 1, 2, 17, 18, 33 and 34 do not affect either word.
- R4: valid_o is high for exactly one cycle. That cycle comes immediately after the high half of slot 34, and ch0_o and ch1_o already carry the new words in that cycle.
- R5: stale_o is 1 with the first valid_o after reset and 0 with every later one. It changes only together with valid_o.
- R6: A request that arrives while a frame is running (any state other than IDLE) is ignored. It produces no extra convert pulse.
- R7: With auto_en_i high, successive conv_o rising edges are max(period_i, 69·H+2) clock cycles apart.
- R8: During reset, conv_o, sck_o, valid_o, stale_o, ch0_o and ch1_o are all 0.
- R9: ch0_o, ch1_o and stale_o hold their values in every cycle in which valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start request, acted on only in IDLE |
| auto_en_i | input | 1 | Enables periodic starts |
| period_i | input | RATE_W | Minimum clock cycles between automatic convert pulses |
| half_div_i | input | DIV_W | SCK half period minus one, in clock cycles; hold constant during a frame |
| sdo_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Active-high convert strobe |
| sck_o | output | 1 | Serial clock, idle low |
| valid_o | output | 1 | One-cycle result strobe |
| stale_o | output | 1 | Marks the first frame after reset |
| ch0_o | output | WORD_W | Channel 0 result, signed |
| ch1_o | output | WORD_W | Channel 1 result, signed |

## Verification
The bench builds the block with DIV_W=4 and RATE_W=12. A 4-bit divider lets it run frames at H=1 and at H=3 within a few hundred cycles each, so both the fastest slot timing and a wider half period are exercised. A 12-bit period lets automatic spacing be tested in both regimes: cases limited by the frame length, and cases limited by the programmed period. The converter model puts an alternating pattern on the guard slots, which exposes any shift in the capture windows.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
    localparam int NUM_CH = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } frame_st_t;
endpackage

// File: rtl/adcrd_tick.sv
module adcrd_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             last
);
    logic [DIV_W-1:0] ph_q;

    assign last = run && (ph_q == half_div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (!run || last) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end
endmodule

// File: rtl/adcrd_rate.sv
module adcrd_rate #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              auto_en,
    input  logic [RATE_W-1:0] period,
    output logic              auto_go
);
    localparam logic [RATE_W-1:0] SAT = '1;

    logic [RATE_W-1:0] since_q;
    logic [RATE_W:0]   since_nx;

    assign since_nx = {1'b0, since_q} + 1'b1;
    assign auto_go  = auto_en && (since_nx >= {1'b0, period});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= SAT;
        end else if (start) begin
            since_q <= '0;
        end else if (since_q != SAT) begin
            since_q <= since_q + 1'b1;
        end
    end
endmodule

// File: rtl/adcrd_deser.sv
module adcrd_deser
    import adcrd_pkg::*;
#(
    parameter int WORD_W = 14,
    parameter int GUARD  = 2,
    parameter int SLOT_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cap,
    input  logic [SLOT_W-1:0]             slot,
    input  logic                          sdo,
    output logic [NUM_CH-1:0][WORD_W-1:0] words
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int FIRST = GUARD + 1 + c * (WORD_W + GUARD);
        localparam int LAST  = FIRST + WORD_W - 1;

        logic              in_win;
        logic [WORD_W-1:0] sh_q;

        assign in_win   = (int'(slot) >= FIRST) && (int'(slot) <= LAST);
        assign words[c] = sh_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_q <= '0;
            end else if (cap && in_win) begin
                sh_q <= {sh_q[WORD_W-2:0], sdo};
            end
        end
    end
endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
    import adcrd_pkg::*;
#(
    parameter int WORD_W = 14,
    parameter int GUARD  = 2,
    parameter int DIV_W  = 8,
    parameter int RATE_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_i,
    input  logic                     auto_en_i,
    input  logic [RATE_W-1:0]        period_i,
    input  logic [DIV_W-1:0]         half_div_i,
    input  logic                     sdo_i,
    output logic                     conv_o,
    output logic                     sck_o,
    output logic                     valid_o,
    output logic                     stale_o,
    output logic signed [WORD_W-1:0] ch0_o,
    output logic signed [WORD_W-1:0] ch1_o
);
    localparam int FRAME_SLOTS = GUARD + NUM_CH * (WORD_W + GUARD);
    localparam int SLOT_W      = $clog2(FRAME_SLOTS + 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS);

    frame_st_t                     state_q, state_d;
    logic [SLOT_W-1:0]             slot_q;
    logic                          first_q;
    logic                          run, last, auto_go, start, cap, frame_end;
    logic [NUM_CH-1:0][WORD_W-1:0] words;

    assign run       = (state_q == ST_CONV) || (state_q == ST_LOW) || (state_q == ST_HIGH);
    assign start     = (state_q == ST_IDLE) && (req_i || auto_go);
    assign cap       = (state_q == ST_LOW) && last;
    assign frame_end = (state_q == ST_HIGH) && last && (slot_q == LAST_SLOT);

    adcrd_tick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_div (half_div_i),
        .last     (last)
    );

    adcrd_rate #(.RATE_W(RATE_W)) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .auto_en (auto_en_i),
        .period  (period_i),
        .auto_go (auto_go)
    );

    adcrd_deser #(.WORD_W(WORD_W), .GUARD(GUARD), .SLOT_W(SLOT_W)) u_deser (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap),
        .slot  (slot_q),
        .sdo   (sdo_i),
        .words (words)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_i || auto_go) state_d = ST_CONV;
            ST_CONV: if (last) state_d = ST_LOW;
            ST_LOW:  if (last) state_d = ST_HIGH;
            ST_HIGH: if (last) state_d = (slot_q == LAST_SLOT) ? ST_DONE : ST_LOW;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and slot counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                slot_q <= '0;
            end else if ((state_q == ST_CONV) && last) begin
                slot_q <= SLOT_W'(1);
            end else if ((state_q == ST_HIGH) && last && (slot_q != LAST_SLOT)) begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_o  <= 1'b0;
            sck_o   <= 1'b0;
            valid_o <= 1'b0;
            stale_o <= 1'b0;
            ch0_o   <= '0;
            ch1_o   <= '0;
            first_q <= 1'b1;
        end else begin
            conv_o  <= (state_d == ST_CONV);
            sck_o   <= (state_d == ST_HIGH);
            valid_o <= (state_d == ST_DONE);
            if (frame_end) begin
                ch0_o   <= signed'(words[0]);
                ch1_o   <= signed'(words[1]);
                stale_o <= first_q;
                first_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adcrd_chk.sv
module adcrd_chk
    import adcrd_pkg::*;
#(
    parameter int WORD_W      = 14,
    parameter int SLOT_W      = 6,
    parameter int FRAME_SLOTS = 34
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     conv_o,
    input logic                     sck_o,
    input logic                     valid_o,
    input logic                     stale_o,
    input logic signed [WORD_W-1:0] ch0_o,
    input logic signed [WORD_W-1:0] ch1_o,
    input frame_st_t                st,
    input logic [SLOT_W-1:0]        slot
);
    AST_CONV_NO_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        conv_o |-> !sck_o); // R1
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(slot) <= FRAME_SLOTS); // R2
    AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(st) == ST_HIGH) && (int'($past(slot)) == FRAME_SLOTS)); // R4
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R4
    AST_STALE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(stale_o)); // R5
    AST_CONV_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_o) |-> ($past(st) == ST_IDLE)); // R6
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(ch0_o) && $stable(ch1_o))); // R9
endmodule

bind dual_adc_reader adcrd_chk #(
    .WORD_W      (WORD_W),
    .SLOT_W      (SLOT_W),
    .FRAME_SLOTS (FRAME_SLOTS)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .conv_o  (conv_o),
    .sck_o   (sck_o),
    .valid_o (valid_o),
    .stale_o (stale_o),
    .ch0_o   (ch0_o),
    .ch1_o   (ch1_o),
    .st      (state_q),
    .slot    (slot_q)
);

// File: tb/test_dual_adc_reader.sv
`timescale 1ns/1ps
module test_dual_adc_reader;
    localparam int WORD_W = 14;
    localparam int DIV_W  = 4;
    localparam int RATE_W = 12;
    localparam int SAT    = (1 << RATE_W) - 1;
    localparam int FRAME  = 34;

    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, auto_en = 1'b0, sdo = 1'b0;
    logic [RATE_W-1:0] period = '0;
    logic [DIV_W-1:0]  half = '0;
    logic conv, sck, valid, stale;
    logic signed [WORD_W-1:0] ch0, ch1;

    dual_adc_reader #(.WORD_W(WORD_W), .GUARD(2), .DIV_W(DIV_W), .RATE_W(RATE_W)) i_dual_adc_reader (
        .clk(clk), .rst_n(rst_n), .req_i(req), .auto_en_i(auto_en), .period_i(period),
        .half_div_i(half), .sdo_i(sdo), .conv_o(conv), .sck_o(sck), .valid_o(valid),
        .stale_o(stale), .ch0_o(ch0), .ch1_o(ch1)
    );

    always #2 clk = ~clk;

    int total = 0, bad = 0;
    longint cyc = 0;

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    // Converter model: samples on convert rise, shifts out the previous sample
    logic [WORD_W-1:0] held0 = 14'h2AAA, held1 = 14'h1555, tx0 = '0, tx1 = '0, ana0 = '0, ana1 = '0;
    int  bs = 0, nrise = 0;
    longint last_rise = 0;
    logic pconv = 1'b0, psck = 1'b0;

    always @(negedge clk) begin
        if (conv && !pconv) begin
            tx0 = held0; tx1 = held1; held0 = ana0; held1 = ana1;
            bs = 0; nrise++; last_rise = cyc;
        end
        if ((pconv && !conv) || (psck && !sck)) begin
            bs++;
            if (bs >= 3 && bs <= 16)       sdo = tx0[16-bs];
            else if (bs >= 19 && bs <= 32) sdo = tx1[32-bs];
            else                           sdo = bs[0];
        end
        pconv = conv;
        psck  = sck;
    end

    // Behavioural reference: elapsed-time view of one frame
    bit mbusy = 0, mfirst = 1, es = 0;
    int t = 0, since = SAT, mh = 1;
    logic [WORD_W-1:0] e0 = '0, e1 = '0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            mbusy = 0; t = 0; since = SAT; mfirst = 1; e0 = '0; e1 = '0; es = 0;
        end else if (!mbusy) begin
            if (req || (auto_en && since + 1 >= int'(period))) begin
                mbusy = 1; t = 0; since = 0; mh = int'(half) + 1;
            end else if (since < SAT) since++;
        end else begin
            t++;
            if (since < SAT) since++;
            if (t == (1 + 2 * FRAME) * mh) begin
                e0 = tx0; e1 = tx1; es = mfirst; mfirst = 0;
            end else if (t == (1 + 2 * FRAME) * mh + 1) mbusy = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit xc, xs, xv;
            int fend;
            fend = (1 + 2 * FRAME) * mh;
            xc = mbusy && (t < mh);
            xs = mbusy && (t >= mh) && (t < fend) && (((t - mh) % (2 * mh)) >= mh);
            xv = mbusy && (t == fend);
            chk(conv == xc, "R1 conv", int'(conv), int'(xc));
            chk(sck == xs, "R2 sck", int'(sck), int'(xs));
            chk(valid == xv, "R4 valid", int'(valid), int'(xv));
            if (xv) begin
                chk(ch0 == e0, "R3 ch0 word", int'(ch0), int'(signed'(e0)));
                chk(ch1 == e1, "R3 ch1 word", int'(ch1), int'(signed'(e1)));
                chk(stale == es, "R5 stale", int'(stale), int'(es));
            end else begin
                chk(ch0 == e0 && ch1 == e1, "R9 hold", int'(ch0), int'(signed'(e0)));
                chk(stale == es, "R9 stale hold", int'(stale), int'(es));
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (mbusy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
    endtask

    task automatic frame(input int a0, input int a1);
        ana0 = WORD_W'(a0);
        ana1 = WORD_W'(a1);
        pulse_req();
        wait_idle();
    endtask

    task automatic measure(input int per, input int expsp);
        int cur;
        longint prev;
        prev = 0;
        period = RATE_W'(per);
        auto_en = 1'b1;
        cur = nrise;
        for (int k = 0; k < 4; k++) begin
            while (nrise == cur) @(negedge clk);
            cur = nrise;
            if (k > 0) chk(last_rise - prev == longint'(expsp), "R7 spacing", int'(last_rise - prev), expsp);
            prev = last_rise;
        end
        auto_en = 1'b0;
        wait_idle();
    endtask

    initial begin
        int n0;
        repeat (3) @(negedge clk);
        chk(conv == 0 && sck == 0 && valid == 0, "R8 reset strobes", int'({conv, sck, valid}), 0);
        chk(ch0 == 0 && ch1 == 0 && stale == 0, "R8 reset data", int'(ch0), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        half = 4'd0;
        frame(8191, -8192);      // first frame: stale, power-up words
        frame(-1, 0);
        frame(16'h1234, -5);
        frame(1, -2);
        half = 4'd2;
        frame(-4096, 4095);
        frame(0, 0);
        frame(16'h0AAA, -16'h0AAA);

        half = 4'd0;
        n0 = nrise;
        pulse_req();
        repeat (30) @(negedge clk);
        pulse_req();             // R6: arrives mid-frame
        wait_idle();
        chk(nrise - n0 == 1, "R6 ignored request", nrise - n0, 1);

        measure(10, 71);         // R7 frame-limited, H=1
        measure(200, 200);       // R7 period-limited
        half = 4'd1;
        measure(100, 140);       // R7 frame-limited, H=2

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule